// File: doc/BRIEF.md
# Speculative Load Address Table

This block remembers which registers hold values fetched by loads that were moved ahead of stores that might write the same memory. When such a load runs, it records its destination register number, the register kind, the address it read and the access size. Every store then presents the byte range it writes, and any recorded entry whose byte range touches that range is removed. A later check operation asks whether an entry for a given register and kind is still present. A hit means the early value can be used. A miss means the load must be issued again or recovery code must run.

The table is fully associative and is searched in two different ways. Checks look entries up by register tag, and stores remove them by address-range overlap. Every shortcut in the design errs toward a miss. A spurious miss costs only performance, while a false hit would let a stale value through.

Top module: `spec_addr_table`

## Requirements
- R1: After reset the table holds no entry, and every lookup reports a miss.
- R2: An allocation records {register, kind, address, size}. A later lookup with the same register and kind hits. A lookup that differs in register or in kind misses.
- R3: The lookup result is combinational on the current table contents. An allocation becomes visible from the cycle after it is presented, so a lookup in the allocation cycle itself does not see it.
- R4: A store removes every entry whose byte range overlaps the store's byte range, and entries that do not overlap survive. A range spans from the address to address plus length minus one. The size code gives the length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R5: When a store and a lookup arrive in the same cycle, the lookup sees the table as it is after the store.
- R6: An allocation marked as having deferred an exception records nothing. It also removes any existing entry with the same register and kind, so a later lookup for that tag misses.
- R7: An allocation for a tag that is already present overwrites that entry in place. No tag is ever held by two entries, and the old address no longer guards the tag.
- R8: When the allocated tag is absent, the entry to write is chosen round-robin. The choice starts at entry 0 after reset and advances by one only when such a new entry is written, wrapping after the last entry.
- R9: A flush empties the table. A lookup in the flush cycle misses, and an allocation in the flush cycle is dropped.
- R10: An allocation in the same cycle as a store whose range overlaps the allocation's range is dropped, and any earlier entry for that tag is removed. With a non-overlapping store in the same cycle, the allocation is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Clear every entry |
| alloc_valid_i | input | 1 | Speculative load allocates |
| alloc_defer_i | input | 1 | Load deferred an exception; record nothing |
| alloc_reg_i | input | REGW | Destination register number |
| alloc_kind_i | input | KINDW | Destination register kind |
| alloc_addr_i | input | AW | Load byte address |
| alloc_size_i | input | 2 | Load size code |
| st_valid_i | input | 1 | Store writes memory this cycle |
| st_addr_i | input | AW | Store byte address |
| st_size_i | input | 2 | Store size code |
| chk_valid_i | input | 1 | Check operation looks up a tag |
| chk_reg_i | input | REGW | Register number to look up |
| chk_kind_i | input | KINDW | Register kind to look up |
| chk_hit_o | output | 1 | Entry present and still valid |

## Verification
The bench sweeps every pairing of load and store address, and of load and store size, over a small address window. It probes each pairing both in the store cycle and in the cycle after, so an off-by-one range end or a store that acts a cycle late shows up as a false hit. Other targeted sequences cover tag reuse, deferred loads, a full table cycling through round-robin eviction, and flush or store collisions with an allocation in the same cycle. A design that appended a duplicate entry instead of overwriting would keep a stale address guard. A design that let a deferred or colliding load keep an older entry would hit where a miss is required.

// File: rtl/spec_tbl_pkg.sv
package spec_tbl_pkg;
   typedef logic [1:0] size_code_t;

   function automatic logic [3:0] size_bytes(input size_code_t code);
      return 4'(1) << code;
   endfunction
endpackage

// File: rtl/sat_overlap.sv
module sat_overlap #(
   parameter int AW = 64
) (
   input  logic [AW-1:0] a_addr_i,
   input  logic [1:0]    a_size_i,
   input  logic [AW-1:0] b_addr_i,
   input  logic [1:0]    b_size_i,
   output logic          ovl_o
);
   import spec_tbl_pkg::*;

   logic [AW:0] a_lo, b_lo, a_end, b_end;

   always_comb begin
      a_lo  = {1'b0, a_addr_i};
      b_lo  = {1'b0, b_addr_i};
      a_end = a_lo + (AW+1)'(size_bytes(a_size_i));
      b_end = b_lo + (AW+1)'(size_bytes(b_size_i));
      ovl_o = (a_lo < b_end) && (b_lo < a_end);
   end
endmodule

// File: rtl/sat_victim.sv
module sat_victim #(
   parameter int ENTRIES = 32,
   localparam int PTRW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   output logic [PTRW-1:0] ptr_o
);
   logic [PTRW-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv_i)
         ptr_q <= (ptr_q == PTRW'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
   end

   assign ptr_o = ptr_q;

   p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ptr_q) < ENTRIES);
endmodule

// File: rtl/sat_slot.sv
module sat_slot #(
   parameter int AW    = 64,
   parameter int REGW  = 7,
   parameter int KINDW = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             wr_i,
   input  logic             drop_i,
   input  logic [REGW-1:0]  wr_reg_i,
   input  logic [KINDW-1:0] wr_kind_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [1:0]       wr_size_i,
   input  logic             st_valid_i,
   input  logic [AW-1:0]    st_addr_i,
   input  logic [1:0]       st_size_i,
   input  logic [REGW-1:0]  chk_reg_i,
   input  logic [KINDW-1:0] chk_kind_i,
   output logic             valid_o,
   output logic             same_tag_o,
   output logic             chk_match_o
);
   logic             valid_q;
   logic [REGW-1:0]  reg_q;
   logic [KINDW-1:0] kind_q;
   logic [AW-1:0]    addr_q;
   logic [1:0]       size_q;
   logic             st_ovl, kill;

   sat_overlap #(.AW(AW)) u_ovl (
      .a_addr_i(addr_q), .a_size_i(size_q),
      .b_addr_i(st_addr_i), .b_size_i(st_size_i),
      .ovl_o(st_ovl)
   );

   assign kill = st_valid_i && st_ovl;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         valid_q <= 1'b0;
      end else if (wr_i) begin
         valid_q <= 1'b1;
         reg_q   <= wr_reg_i;
         kind_q  <= wr_kind_i;
         addr_q  <= wr_addr_i;
         size_q  <= wr_size_i;
      end else if (drop_i || kill) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o     = valid_q;
   assign same_tag_o  = valid_q && (reg_q == wr_reg_i) && (kind_q == wr_kind_i);
   assign chk_match_o = valid_q && !kill && (reg_q == chk_reg_i) && (kind_q == chk_kind_i);

   // R4: a store touching the held range leaves no entry guarding that range
   p_store_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && kill) |=> (!valid_q || addr_q != $past(addr_q) || size_q != $past(size_q)));
endmodule

// File: rtl/spec_addr_table.sv
module spec_addr_table #(
   parameter int ENTRIES = 32,
   parameter int AW      = 64,
   parameter int REGW    = 7,
   parameter int KINDW   = 1,
   localparam int PTRW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             alloc_valid_i,
   input  logic             alloc_defer_i,
   input  logic [REGW-1:0]  alloc_reg_i,
   input  logic [KINDW-1:0] alloc_kind_i,
   input  logic [AW-1:0]    alloc_addr_i,
   input  logic [1:0]       alloc_size_i,
   input  logic             st_valid_i,
   input  logic [AW-1:0]    st_addr_i,
   input  logic [1:0]       st_size_i,
   input  logic             chk_valid_i,
   input  logic [REGW-1:0]  chk_reg_i,
   input  logic [KINDW-1:0] chk_kind_i,
   output logic             chk_hit_o
);
   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (AW >= 4)      else $error("AW must be at least 4");
      assert (REGW >= 1 && KINDW >= 1) else $error("tag widths must be positive");
   end

   logic [ENTRIES-1:0] valid_vec, same_vec, match_vec, wr_vec, drop_vec;
   logic [PTRW-1:0]    ptr;
   logic               any_same, alloc_st_ovl, blocked, do_write, adv;

   sat_overlap #(.AW(AW)) u_alloc_ovl (
      .a_addr_i(alloc_addr_i), .a_size_i(alloc_size_i),
      .b_addr_i(st_addr_i), .b_size_i(st_size_i),
      .ovl_o(alloc_st_ovl)
   );

   assign any_same = |same_vec;
   assign blocked  = alloc_defer_i || (st_valid_i && alloc_st_ovl);
   assign do_write = alloc_valid_i && !flush_i && !blocked;
   assign adv      = do_write && !any_same;

   sat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .ptr_o(ptr)
   );

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      assign wr_vec[i]   = do_write && (any_same ? same_vec[i] : (ptr == PTRW'(i)));
      assign drop_vec[i] = alloc_valid_i && blocked && same_vec[i];

      sat_slot #(.AW(AW), .REGW(REGW), .KINDW(KINDW)) u_slot (
         .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
         .wr_i(wr_vec[i]), .drop_i(drop_vec[i]),
         .wr_reg_i(alloc_reg_i), .wr_kind_i(alloc_kind_i),
         .wr_addr_i(alloc_addr_i), .wr_size_i(alloc_size_i),
         .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
         .chk_reg_i(chk_reg_i), .chk_kind_i(chk_kind_i),
         .valid_o(valid_vec[i]), .same_tag_o(same_vec[i]), .chk_match_o(match_vec[i])
      );
   end

   assign chk_hit_o = chk_valid_i && !flush_i && (|match_vec);

   // R7: no tag is held twice
   p_unique_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec) && $onehot0(same_vec));
   // R9: flush empties the whole table
   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_vec == '0));
   // R6: a deferred load leaves its tag unfindable in the next cycle
   p_defer_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid_i && alloc_defer_i) |=>
         !(chk_hit_o && chk_reg_i == $past(alloc_reg_i) && chk_kind_i == $past(alloc_kind_i)));
   // R8: occupancy grows by at most one entry per cycle
   p_fill_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 ($countones(valid_vec) <= $countones($past(valid_vec)) + 1));
endmodule

// File: tb/spec_addr_table_bench.sv
module spec_addr_table_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 16;
   localparam int RW = 4;
   localparam int KW = 1;

   logic clk = 0, rst_n = 0, flush = 0;
   logic a_v = 0, a_def = 0;
   logic [RW-1:0] a_reg = '0, c_reg = '0;
   logic [KW-1:0] a_kind = '0, c_kind = '0;
   logic [AW-1:0] a_addr = '0, s_addr = '0;
   logic [1:0] a_size = '0, s_size = '0;
   logic s_v = 0, c_v = 0, hit;
   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spec_addr_table #(.ENTRIES(N), .AW(AW), .REGW(RW), .KINDW(KW)) u_spec_addr_table (
      .clk(clk), .rst_n(rst_n), .flush_i(flush),
      .alloc_valid_i(a_v), .alloc_defer_i(a_def), .alloc_reg_i(a_reg),
      .alloc_kind_i(a_kind), .alloc_addr_i(a_addr), .alloc_size_i(a_size),
      .st_valid_i(s_v), .st_addr_i(s_addr), .st_size_i(s_size),
      .chk_valid_i(c_v), .chk_reg_i(c_reg), .chk_kind_i(c_kind),
      .chk_hit_o(hit)
   );

   task automatic idle();
      flush = 0; a_v = 0; a_def = 0; s_v = 0; c_v = 0;
   endtask

   task automatic cyc();
      @(negedge clk); idle();
   endtask

   task automatic alloc(input int r, input int k, input int ad, input int sz);
      a_v = 1; a_reg = RW'(r); a_kind = KW'(k); a_addr = AW'(ad); a_size = 2'(sz);
   endtask

   task automatic store(input int ad, input int sz);
      s_v = 1; s_addr = AW'(ad); s_size = 2'(sz);
   endtask

   task automatic look(input int r, input int k);
      c_v = 1; c_reg = RW'(r); c_kind = KW'(k);
   endtask

   task automatic expect_hit(input string req, input logic exp);
      #1;
      checks++;
      if (hit !== exp) begin
         fails++;
         $display("FAIL %s: hit=%b expected=%b", req, hit, exp);
      end
   endtask

   task automatic probe(input string req, input int r, input int k, input logic exp);
      look(r, k); expect_hit(req, exp); cyc();
   endtask

   task automatic do_reset();
      rst_n = 0; idle(); cyc(); cyc(); rst_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1
      for (int r = 0; r < 4; r++) probe("R1", r, r % 2, 1'b0);

      // R2 and R3
      alloc(3, 0, 'h100, 3); look(3, 0); expect_hit("R3", 1'b0); cyc();
      probe("R2", 3, 0, 1'b1);
      probe("R2", 3, 1, 1'b0);
      probe("R2", 2, 0, 1'b0);

      // R4 and R5 exhaustive overlap sweep
      flush = 1; cyc();
      for (int a = 0; a < 16; a++)
         for (int sa = 0; sa < 4; sa++)
            for (int b = 0; b < 16; b++)
               for (int sb = 0; sb < 4; sb++) begin
                  automatic int la = 1 << sa;
                  automatic int lb = 1 << sb;
                  automatic logic ov = ((32 + a) < (32 + b + lb)) && ((32 + b) < (32 + a + la));
                  alloc(1, 0, 32 + a, sa); cyc();
                  store(32 + b, sb); look(1, 0); expect_hit("R5", !ov); cyc();
                  probe("R4", 1, 0, !ov);
               end

      // R6
      flush = 1; cyc();
      alloc(5, 0, 'h300, 2); cyc();
      probe("R6", 5, 0, 1'b1);
      alloc(5, 0, 'h300, 2); a_def = 1; cyc();
      probe("R6", 5, 0, 1'b0);
      alloc(9, 1, 'h340, 0); a_def = 1; cyc();
      probe("R6", 9, 1, 1'b0);

      // R7
      alloc(6, 0, 'h40, 3); cyc();
      alloc(6, 0, 'h80, 3); cyc();
      store('h40, 3); cyc();
      probe("R7", 6, 0, 1'b1);
      store('h84, 0); cyc();
      probe("R7", 6, 0, 1'b0);

      // R8 round robin from a fresh reset
      do_reset();
      for (int t = 1; t <= 4; t++) begin alloc(t, 0, 'h100 * t, 0); cyc(); end
      alloc(2, 0, 'h900, 0); cyc();            // existing tag: pointer holds
      alloc(5, 0, 'h500, 0); cyc();            // evicts slot 0 (tag 1)
      probe("R8", 1, 0, 1'b0);
      for (int t = 2; t <= 5; t++) probe("R8", t, 0, 1'b1);
      alloc(6, 0, 'h600, 0); cyc();            // evicts slot 1 (tag 2)
      probe("R8", 2, 0, 1'b0);
      probe("R8", 3, 0, 1'b1);

      // R9
      flush = 1; alloc(7, 1, 'h700, 1); look(3, 0); expect_hit("R9", 1'b0); cyc();
      for (int t = 3; t <= 6; t++) probe("R9", t, 0, 1'b0);
      probe("R9", 7, 1, 1'b0);

      // R10
      alloc(8, 0, 'h200, 2); cyc();
      alloc(8, 0, 'h200, 2); store('h203, 0); cyc();
      probe("R10", 8, 0, 1'b0);
      alloc(8, 0, 'h200, 2); store('h204, 0); cyc();
      probe("R10", 8, 0, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule